// File: doc/BRIEF.md
# Posted-Write Register Bridge Between Two Clock Domains

This block carries register accesses from a bus clock domain into a timer clock domain that may be slower than it or unrelated to it, and carries register reads back. Each timer-domain register has its own crossing lane. A lane uses a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. The write data is held in the bus domain and stays stable until the acknowledge comes back. Because every lane keeps its own handshake, writes to different registers can be in flight at the same time.

The bridge starts in handshake mode after reset. In this mode a bus write to a timer register stays stalled until its acknowledge has returned to the bus domain. The value is therefore already in the timer register when the write completes. This works for any ratio between the two clocks, but every write costs several cycles.

A control bit selects posted mode. In posted mode a write is accepted in the cycle it is presented, and the crossing finishes in the background. A status register holds one pending bit per timer register, and software polls it to see when each write has landed. Reads of timer registers always go through a handshake on a separate read lane.

Top module: `tmr_reg_bridge`

## Requirements
- R1: After reset, the control register reads 0 (handshake mode), every pending bit reads 0, every timer register holds 0, and no load strobe is active.
- R2: Address map. Offsets 0 to NREG-1 select timer registers 0 to NREG-1. Offset NREG is the control register, where bit 0 = 1 selects posted mode and the other bits read 0. Offset NREG+1 is the pending status register, where bit i belongs to timer register i. Writes to the status offset are ignored.
- R3: With the control bit at 0, a write to a timer register is stalled (bus_ready low) for at least one cycle. When it completes, the timer register already holds the written value.
- R4: With the control bit at 1, a write to a timer register whose pending bit is clear completes in the cycle it is presented. The pending bit reads 1 in the following cycle.
- R5: A pending bit clears only after the written value is visible on tmr_regs. Once it has cleared, tmr_regs shows that value.
- R6: A posted write to a register whose pending bit is still set is stalled until that bit clears. The register then ends up holding the later value.
- R7: Posted writes to different registers can be outstanding together, each completing with no wait, and their pending bits are all set at the same time.
- R8: A read of a timer register returns its current timer-domain value through a handshake. The read is stalled while that register's pending bit is set, so it returns the most recently written value.
- R9: Each write that lands raises tmr_wstb[i] for exactly one timer clock cycle. The held write data does not change while its pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW = clog2(NREG+2) | Register offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes at the clock edge where bus_sel and bus_ready are both high |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer domain |
| tmr_regs | output | NREG*DW | Timer-domain register values, register i in bits [i*DW +: DW] |
| tmr_wstb | output | NREG | One-cycle pulse when a write lands in register i |

## Verification
The assertions check four rules on every clock. The held write data never changes while a write is pending. A lane is never relaunched while busy. The load strobe never lasts more than one timer cycle. An accepted posted write always shows up as pending in the next cycle. They also check that the read index stays stable while a read is in flight. The scenarios in the bench are needed for the end-to-end facts: the number of stall cycles in each mode, the values that arrive in the timer domain, the stall on a busy register, the overlap of writes to different registers, and reads that see the latest write. None of these can be expressed as a single-clock property.

// File: rtl/tmr_bridge_pkg.sv
`timescale 1ns/1ps
// Shared types for the posted-write register bridge.
package tmr_bridge_pkg;
    // Bus-side access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // accepting a new access
        ST_WWAIT = 2'd1,   // handshake-mode write waiting for acknowledge
        ST_RWAIT = 2'd2    // read waiting for timer-domain data
    } bus_state_e;
endpackage

// File: rtl/bridge_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for level or toggle signals.
// Assumes: each bit is a toggle/level that stays stable for at least
// two destination clock cycles; bits are not treated as a coherent bus.
module bridge_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bridge_wr_lane.sv
`timescale 1ns/1ps
// One write-crossing lane: bus-side toggle request plus held data,
// timer-side register loaded when the synchronized request changes,
// acknowledge toggle synchronized back to form the pending flag.
// Assumes: launch is only raised while pend is low.
module bridge_wr_lane #(
    parameter int          DW      = 32,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          bus_clk,
    input  logic          bus_rst_n,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    input  logic          tmr_clk,
    input  logic          tmr_rst_n,
    output logic [DW-1:0] tmr_q,
    output logic          tmr_stb
);
    logic          req_t;
    logic [DW-1:0] hold;
    logic          ack_t;
    logic          ack_s;
    logic          req_s;

    // Bus side: capture data and flip the request on launch
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            req_t <= 1'b0;
            hold  <= RST_VAL;
        end else if (launch) begin
            req_t <= ~req_t;
            hold  <= wdata;
        end
    end

    bridge_sync2 #(.W(1)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_t), .q(ack_s)
    );

    assign pend = req_t ^ ack_s;

    bridge_sync2 #(.W(1)) u_req_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_t), .q(req_s)
    );

    // Timer side: load the held data and echo the request as acknowledge
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            ack_t   <= 1'b0;
            tmr_q   <= RST_VAL;
            tmr_stb <= 1'b0;
        end else begin
            tmr_stb <= (req_s != ack_t);
            if (req_s != ack_t) begin
                tmr_q <= hold;
                ack_t <= req_s;
            end
        end
    end

    // R9: held data frozen while the crossing is in flight
    a_r9_hold_stable: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        pend |=> $stable(hold));

    // R6: a busy lane is never relaunched
    a_r6_no_relaunch: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        launch |-> !pend);

    // R9: load strobe lasts a single timer cycle
    a_r9_single_strobe: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        tmr_stb |=> !tmr_stb);
endmodule

// File: rtl/bridge_rd_port.sv
`timescale 1ns/1ps
// Read-crossing port shared by all timer registers: the bus side flips a
// request and holds the register index; the timer side samples the
// selected register and flips the acknowledge; done is high when both agree.
// Assumes: launch is only raised while done is high.
module bridge_rd_port #(
    parameter int NREG = 4,
    parameter int DW   = 32,
    parameter int IW   = 2
) (
    input  logic               bus_clk,
    input  logic               bus_rst_n,
    input  logic               launch,
    input  logic [IW-1:0]      idx,
    output logic               done,
    output logic [DW-1:0]      rdata,
    input  logic               tmr_clk,
    input  logic               tmr_rst_n,
    input  logic [NREG*DW-1:0] tmr_regs
);
    logic          rreq_t;
    logic [IW-1:0] idx_hold;
    logic          rack_t;
    logic          rack_s;
    logic          rreq_s;
    logic [DW-1:0] rhold;

    // Bus side: latch index and flip request on launch
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            rreq_t   <= 1'b0;
            idx_hold <= '0;
        end else if (launch) begin
            rreq_t   <= ~rreq_t;
            idx_hold <= idx;
        end
    end

    bridge_sync2 #(.W(1)) u_rack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(rack_t), .q(rack_s)
    );

    assign done  = (rreq_t == rack_s);
    assign rdata = rhold;

    bridge_sync2 #(.W(1)) u_rreq_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d(rreq_t), .q(rreq_s)
    );

    // Timer side: sample the indexed register and acknowledge
    always_ff @(posedge tmr_clk) begin
        if (!tmr_rst_n) begin
            rack_t <= 1'b0;
            rhold  <= '0;
        end else if (rreq_s != rack_t) begin
            rhold  <= tmr_regs[int'(idx_hold)*DW +: DW];
            rack_t <= rreq_s;
        end
    end

    // R8: a read is only started when the previous one is finished
    a_r8_launch_when_done: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        launch |-> done);

    // R8: index held steady while the timer side may sample it
    a_r8_idx_stable: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !done |=> $stable(idx_hold));
endmodule

// File: rtl/tmr_reg_bridge.sv
`timescale 1ns/1ps
// Posted-write register bridge, top level. Decodes bus accesses, keeps the
// posted-mode control bit and the pending status, sequences handshake-mode
// writes and reads, and instantiates one write lane per timer register.
// Assumes: NREG >= 2; the bus master holds sel/we/addr/wdata until ready.
module tmr_reg_bridge
    import tmr_bridge_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG + 2),
    localparam int IW  = $clog2(NREG)
) (
    input  logic               bus_clk,
    input  logic               bus_rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_ready,
    input  logic               tmr_clk,
    input  logic               tmr_rst_n,
    output logic [NREG*DW-1:0] tmr_regs,
    output logic [NREG-1:0]    tmr_wstb
);
    localparam logic [AW-1:0] CTRL_A = AW'(NREG);
    localparam logic [AW-1:0] STAT_A = AW'(NREG + 1);

    bus_state_e      st, st_nxt;
    logic            posted;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] pend;
    logic [NREG-1:0] lane_go;
    logic            is_treg;
    logic [IW-1:0]   widx;
    logic            wr_go;
    logic            rd_go;
    logic            rd_done;
    logic [DW-1:0]   rd_val;

    assign is_treg = (bus_addr < CTRL_A);
    assign widx    = bus_addr[IW-1:0];

    // Access sequencing: ready, lane launches and next state
    always_comb begin
        st_nxt    = st;
        bus_ready = 1'b0;
        wr_go     = 1'b0;
        rd_go     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (bus_sel) begin
                    if (!is_treg) begin
                        bus_ready = 1'b1;
                    end else if (!pend[widx]) begin
                        if (bus_we) begin
                            wr_go     = 1'b1;
                            bus_ready = posted;
                            if (!posted) st_nxt = ST_WWAIT;
                        end else begin
                            rd_go  = 1'b1;
                            st_nxt = ST_RWAIT;
                        end
                    end
                end
            end
            ST_WWAIT: begin
                bus_ready = !pend[cur_idx];
                if (!pend[cur_idx]) st_nxt = ST_IDLE;
            end
            ST_RWAIT: begin
                bus_ready = rd_done;
                if (rd_done) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Read data selection for local and crossed registers
    always_comb begin
        bus_rdata = '0;
        if (st == ST_RWAIT) begin
            bus_rdata = rd_val;
        end else if (st == ST_IDLE) begin
            if (bus_addr == CTRL_A)      bus_rdata = DW'(posted);
            else if (bus_addr == STAT_A) bus_rdata = DW'(pend);
        end
    end

    // State, latched register index and posted-mode control bit
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            st      <= ST_IDLE;
            cur_idx <= '0;
            posted  <= 1'b0;
        end else begin
            st <= st_nxt;
            if (wr_go || rd_go) cur_idx <= widx;
            if (st == ST_IDLE && bus_sel && bus_we && bus_addr == CTRL_A)
                posted <= bus_wdata[0];
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_lane
        assign lane_go[i] = wr_go && (widx == IW'(i));

        bridge_wr_lane #(.DW(DW), .RST_VAL('0)) u_lane (
            .bus_clk  (bus_clk),
            .bus_rst_n(bus_rst_n),
            .launch   (lane_go[i]),
            .wdata    (bus_wdata),
            .pend     (pend[i]),
            .tmr_clk  (tmr_clk),
            .tmr_rst_n(tmr_rst_n),
            .tmr_q    (tmr_regs[i*DW +: DW]),
            .tmr_stb  (tmr_wstb[i])
        );
    end

    bridge_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .launch   (rd_go),
        .idx      (widx),
        .done     (rd_done),
        .rdata    (rd_val),
        .tmr_clk  (tmr_clk),
        .tmr_rst_n(tmr_rst_n),
        .tmr_regs (tmr_regs)
    );

    // R4: an accepted posted write shows as pending in the next cycle
    a_r4_posted_pending: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (st == ST_IDLE && bus_sel && bus_we && is_treg && bus_ready)
        |=> pend[$past(widx)]);
endmodule

// File: tb/test_tmr_reg_bridge.sv
`timescale 1ns/1ps
// Bench for the posted-write register bridge: a vector table walked by one
// loop, then directed checks for reset, stalls, overlap and read ordering.
module test_tmr_reg_bridge;
    localparam int NREG = 4;
    localparam int DW   = 32;
    localparam int AW   = $clog2(NREG + 2);
    localparam logic [AW-1:0] CTRL_A = AW'(NREG);
    localparam logic [AW-1:0] STAT_A = AW'(NREG + 1);

    logic               bus_clk = 1'b0;
    logic               tmr_clk = 1'b0;
    logic               bus_rst_n = 1'b0;
    logic               tmr_rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_we = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic               bus_ready;
    logic [NREG*DW-1:0] tmr_regs;
    logic [NREG-1:0]    tmr_wstb;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int stb_cnt [NREG];
    int exp_cnt [NREG];

    always #2.5 bus_clk = ~bus_clk;   // 200 MHz
    always #6.5 tmr_clk = ~tmr_clk;   // unrelated, slower timer clock

    tmr_reg_bridge #(.NREG(NREG), .DW(DW)) i_tmr_reg_bridge (
        .bus_clk, .bus_rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
        .bus_rdata, .bus_ready, .tmr_clk, .tmr_rst_n, .tmr_regs, .tmr_wstb
    );

    // Count load strobes away from the timer clock edge
    always @(negedge tmr_clk) begin
        if (tmr_rst_n)
            for (int i = 0; i < NREG; i++)
                if (tmr_wstb[i]) stb_cnt[i]++;
    end

    typedef struct packed {
        logic        pm;
        logic [1:0]  idx;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 32'h1111_0001},
        '{1'b0, 2'd3, 32'hA5A5_5A5A},
        '{1'b1, 2'd1, 32'h0000_00FF},
        '{1'b1, 2'd2, 32'hDEAD_BEEF},
        '{1'b0, 2'd2, 32'h0BAD_F00D},
        '{1'b1, 2'd0, 32'hFFFF_FFFF},
        '{1'b1, 2'd3, 32'h0000_0000},
        '{1'b0, 2'd1, 32'h8000_0001}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One bus access; returns read data and the number of wait cycles
    task automatic xfer(input logic we, input logic [AW-1:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output int waits);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        waits = 0;
        #1;
        while (!bus_ready) begin
            @(negedge bus_clk); #1;
            waits++;
        end
        rd = bus_rdata;
        @(posedge bus_clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Poll the status register until bit i clears
    task automatic drain(input int i);
        logic [31:0] s;
        int w;
        for (int k = 0; k < 200; k++) begin
            xfer(1'b0, STAT_A, '0, s, w);
            if (!s[i]) break;
        end
    endtask

    function automatic logic [31:0] treg(input int i);
        return tmr_regs[i*DW +: DW];
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        for (int i = 0; i < NREG; i++) begin stb_cnt[i] = 0; exp_cnt[i] = 0; end
        repeat (10) @(negedge bus_clk);
        bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R1: reset state
        xfer(1'b0, CTRL_A, '0, rd, w);
        check(rd == 32'd0, "R1 control after reset", rd, 32'd0);
        xfer(1'b0, STAT_A, '0, rd, w);
        check(rd == 32'd0, "R1 pending after reset", rd, 32'd0);
        for (int i = 0; i < NREG; i++)
            check(treg(i) == 32'd0, "R1 timer register after reset", treg(i), 32'd0);
        check(tmr_wstb == '0, "R1 strobes idle after reset", 32'(tmr_wstb), 32'd0);

        // R2: status offset ignores writes, control readback
        xfer(1'b1, STAT_A, 32'hFFFF_FFFF, rd, w);
        xfer(1'b0, STAT_A, '0, rd, w);
        check(rd == 32'd0, "R2 status write ignored", rd, 32'd0);
        xfer(1'b1, CTRL_A, 32'hFFFF_FFFF, rd, w);
        xfer(1'b0, CTRL_A, '0, rd, w);
        check(rd == 32'd1, "R2 control keeps only bit 0", rd, 32'd1);

        // Vector table: mode, register, data
        foreach (VEC[v]) begin
            int ix;
            ix = int'(VEC[v].idx);
            xfer(1'b1, CTRL_A, {31'd0, VEC[v].pm}, rd, w);
            xfer(1'b1, AW'(ix), VEC[v].data, rd, w);
            exp_cnt[ix]++;
            if (!VEC[v].pm) begin
                check(w > 0, "R3 handshake write stalls", w, 1);
                check(treg(ix) == VEC[v].data, "R3 value landed at completion",
                      treg(ix), VEC[v].data);
            end else begin
                check(w == 0, "R4 posted write zero wait", w, 0);
                xfer(1'b0, STAT_A, '0, rd, w);
                check(rd[ix] == 1'b1, "R4 pending set after posted write", rd, 32'(1 << ix));
                drain(ix);
                check(treg(ix) == VEC[v].data, "R5 value visible once pending clears",
                      treg(ix), VEC[v].data);
            end
            xfer(1'b0, AW'(ix), '0, rd, w);
            check(rd == VEC[v].data, "R8 readback through handshake", rd, VEC[v].data);
        end

        // R6: second posted write to a busy register stalls
        xfer(1'b1, CTRL_A, 32'd1, rd, w);
        xfer(1'b1, AW'(2), 32'h1234_5678, rd, w);
        check(w == 0, "R6 first posted write", w, 0);
        xfer(1'b1, AW'(2), 32'h9ABC_DEF0, rd, w);
        check(w > 0, "R6 write to pending register stalls", w, 1);
        exp_cnt[2] += 2;
        drain(2);
        check(treg(2) == 32'h9ABC_DEF0, "R6 later value wins", treg(2), 32'h9ABC_DEF0);

        // R7: overlapping posted writes to different registers
        xfer(1'b1, AW'(0), 32'hC0C0_0000, rd, w);
        check(w == 0, "R7 overlap write reg0", w, 0);
        xfer(1'b1, AW'(1), 32'hC1C1_1111, rd, w);
        check(w == 0, "R7 overlap write reg1", w, 0);
        xfer(1'b1, AW'(3), 32'hC3C3_3333, rd, w);
        check(w == 0, "R7 overlap write reg3", w, 0);
        exp_cnt[0]++; exp_cnt[1]++; exp_cnt[3]++;
        xfer(1'b0, STAT_A, '0, rd, w);
        check(rd == 32'hB, "R7 three pending bits together", rd, 32'hB);

        // R8: read of a pending register waits and returns the new value
        xfer(1'b0, AW'(3), '0, rd, w);
        check(rd == 32'hC3C3_3333, "R8 read after pending write", rd, 32'hC3C3_3333);
        check(w > 0, "R8 read stalled", w, 1);
        drain(0); drain(1);

        // R9: one strobe per landed write
        repeat (20) @(negedge bus_clk);
        for (int i = 0; i < NREG; i++)
            check(stb_cnt[i] == exp_cnt[i], "R9 strobe count", stb_cnt[i], exp_cnt[i]);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule